// File: doc/BRIEF.md
# I2C Register-Port Target

This block is an I2C target that lets an external host read and write a 256-entry, byte-wide register space over a two-wire bus. It runs on a fast system clock and oversamples SCL and SDA. From the sampled lines it detects START, repeated START and STOP, and it runs a protocol state machine. It answers to a 7-bit device address whose upper six bits are fixed at 6'b010110. The lowest address bit is taken from a strap input.

The block keeps an 8-bit sub-address pointer. The first byte of a write transaction loads the pointer. Every data byte that is written or read then advances it by one. A read that has no sub-address phase starts wherever the pointer currently points. On the register side the block offers a write strobe, an address (the live pointer), write data and a combinational read-data input. SDA is driven open-drain: the block only ever pulls the line low, and the external wire is the AND of all drivers.

States: ST_IDLE (bus free), ST_ADDR (shift in the address byte), ST_ADDR_ACK (drive the address ACK), ST_SUB / ST_SUB_ACK (receive and acknowledge the sub-address), ST_WDATA / ST_WDATA_ACK (receive and acknowledge a data byte), ST_RDATA (shift a register byte out), ST_RACK (sample the host's ACK), and ST_IGNORE (stay released until the next START or STOP).

Transitions:
- Any state goes to ST_ADDR on START and to ST_IDLE on STOP or when the enable input is low.
- ST_ADDR goes to ST_ADDR_ACK on an address match and to ST_IGNORE otherwise.
- ST_ADDR_ACK goes to ST_SUB for a write and to ST_RDATA for a read.
- ST_SUB goes to ST_SUB_ACK, then to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK, then back to ST_WDATA.
- ST_RDATA goes to ST_RACK after the eighth bit.
- ST_RACK goes to ST_RDATA when the host ACKs and to ST_IGNORE when it NACKs.

Top module: `i2c_regport`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth SCL clock) an address byte whose upper seven bits equal {6'b010110, addr_strap}. With the strap low the write/read address bytes are 0x58/0x59. With the strap high they are 0x5A/0x5B. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R2: On an address mismatch the block leaves SDA released for the rest of the transaction, issues no register write and leaves the pointer unchanged until the next START or STOP.
- R3: In a write, the first byte after the address is the sub-address. Each later byte gives exactly one single-cycle reg_wr_en pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. Every byte of a matched write, including the address and the sub-address, is acknowledged.
- R4: A write made of only the address and the sub-address, closed by STOP, loads the pointer with the sub-address and causes no register write.
- R5: A read sends the register at the pointer MSB-first. The pointer is 0x00 after reset; otherwise it is the value left by the last write. reg_rdata is taken in the system-clock cycle in which the SCL fall that starts the byte is detected.
- R6: After each byte it sends, the block samples the host's acknowledge bit. An ACK (SDA low) makes it send the next register. A NACK (SDA high) makes it release SDA and stay silent until START or STOP.
- R7: The pointer advances by one after every byte written or read, wraps from 0xFF to 0x00, and is 0x00 after reset.
- R8: A repeated START is handled like a fresh START. A write of the sub-address, followed by a repeated START and then a read, returns data starting at the new pointer.
- R9: While enable is low, the block keeps SDA released, issues no writes and ignores all bus activity.
- R10: SCL and SDA pass through two-flop synchronizers. START is SDA falling while SCL is high; STOP is SDA rising while SCL is high. Data is sampled on SCL rising edges, and the block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable; the bus is ignored while low |
| addr_strap | input | 1 | Level that sets bit 0 of the 7-bit device address |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_addr | output | 8 | Register address (the sub-address pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr, combinational |

## Verification
The bench drives several transaction types:
- A read straight after reset checks that the power-on pointer is used.
- A burst write followed by a pointer-only write tells loading the pointer apart from writing a register.
- A write of the sub-address, then a repeated START, then a read checks that the new pointer is used within a single bus ownership.
- Transactions to the wrong address, with the strap flipped, and with enable low each show that the block stays silent and leaves the pointer and registers alone.
- A burst that straddles 0xFF checks the wrap.
- A NACK followed by stray clocks checks that SDA is released.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_p;
    logic              sda_p;

    assign raw = {sda_in, scl_in};

    // One synchronizer chain per bus line; idle bus level is high.
    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[0];
    assign sda_s = synced[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    // R10: a bus condition is only ever seen while SCL stays high
    assert_cond_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> ($past(scl_s) && scl_s));

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= AW'(ptr + 1'b1);
    end

    assert_ptr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)));

    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (ptr == '1)) |=> (ptr == '0));

    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(ptr));

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b010110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              addr_strap,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_drive_low,
    output logic              wr_pulse,
    output logic [BYTE_W-1:0] wdata,
    output logic              ptr_load,
    output logic [BYTE_W-1:0] ptr_load_val,
    output logic              ptr_inc
);
    localparam logic [BIT_CNT_W-1:0] FULL_BYTE = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT  = BIT_CNT_W'(BYTE_W - 1);

    tgt_state_e           state;
    logic [BYTE_W-1:0]    shreg;
    logic [BIT_CNT_W-1:0] cnt;
    logic                 rw;
    logic                 host_nack;
    logic                 addr_hit;
    logic                 byte_in_done;
    logic                 byte_out_done;

    assign addr_hit      = (shreg[BYTE_W-1:1] == {DEV_ADDR_HI, addr_strap});
    assign byte_in_done  = scl_fall && (cnt == FULL_BYTE);
    assign byte_out_done = scl_fall && (cnt == LAST_BIT);

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            cnt       <= '0;
            rw        <= 1'b0;
            host_nack <= 1'b1;
            wr_pulse  <= 1'b0;
            wdata     <= '0;
        end else begin
            wr_pulse <= 1'b0;
            if (!enable) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (start_det) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: begin
                    end
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise && cnt != FULL_BYTE) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= BIT_CNT_W'(cnt + 1'b1);
                        end else if (byte_in_done) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    rw    <= shreg[0];
                                    state <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_SUB) begin
                                state <= ST_SUB_ACK;
                            end else begin
                                wr_pulse <= 1'b1;
                                wdata    <= shreg;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg <= reg_rdata;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (byte_out_done) begin
                            cnt   <= '0;
                            state <= ST_RACK;
                        end else if (scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            cnt   <= BIT_CNT_W'(cnt + 1'b1);
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_nack <= sda_s;
                        end else if (scl_fall) begin
                            if (!host_nack) begin
                                shreg <= reg_rdata;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive_low = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sda_drive_low = 1'b1;
            ST_RDATA:                              sda_drive_low = ~shreg[BYTE_W-1];
            default:                               sda_drive_low = 1'b0;
        endcase
        ptr_load     = enable && !start_det && !stop_det && (state == ST_SUB) && byte_in_done;
        ptr_load_val = shreg;
        ptr_inc      = wr_pulse ||
                       (enable && !start_det && !stop_det && (state == ST_RDATA) && byte_out_done);
    end

    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    assert_wr_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($past(state) == ST_WDATA));

    assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA || state == ST_RACK) |-> !wr_pulse);

    assert_off_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sda_drive_low);

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (sda_drive_low != $past(sda_drive_low))) |-> !scl_s);

    assert_ignore_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> !wr_pulse);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_ADDR_HI = 6'b010110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       addr_strap,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    output logic       reg_wr_en,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata
);
    import i2c_tgt_pkg::*;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ptr_load, ptr_inc;
    logic [BYTE_W-1:0] ptr_load_val;

    i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .addr_strap    (addr_strap),
        .scl_s         (scl_s),
        .sda_s         (sda_s),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .reg_rdata     (reg_rdata),
        .sda_drive_low (sda_drive_low),
        .wr_pulse      (reg_wr_en),
        .wdata         (reg_wdata),
        .ptr_load      (ptr_load),
        .ptr_load_val  (ptr_load_val),
        .ptr_inc       (ptr_inc)
    );

    i2c_tgt_ptr #(.AW(BYTE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (reg_addr)
    );

endmodule

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       addr_strap = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       sda_drive_low;
    logic       reg_wr_en;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_line;

    logic [7:0] mem [256];
    int         wr_cnt = 0;
    int         drv_cycles = 0;
    int         r10_bad = 0;
    logic       prev_drv = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = host_sda & ~sda_drive_low;
    assign reg_rdata = mem[reg_addr];

    i2c_regport u_i2c_regport (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .addr_strap    (addr_strap),
        .scl_in        (host_scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // Register model and bus monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (reg_wr_en) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (sda_drive_low) drv_cycles <= drv_cycles + 1;
        if (sda_drive_low != prev_drv && host_scl) r10_bad <= r10_bad + 1;
        prev_drv <= sda_drive_low;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; qw();
        host_scl = 1'b1; qw();
        host_sda = 1'b0; qw();
        host_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; qw();
        host_scl = 1'b1; qw();
        host_sda = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; qw();
            host_scl = 1'b1; qw(); qw();
            host_scl = 1'b0; qw();
        end
        host_sda = 1'b1; qw();
        host_scl = 1'b1; qw();
        ack = sda_line; qw();
        host_scl = 1'b0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        b = '0;
        host_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qw();
            host_scl = 1'b1; qw();
            b = {b[6:0], sda_line}; qw();
            host_scl = 1'b0; qw();
        end
        host_sda = nack; qw();
        host_scl = 1'b1; qw(); qw();
        host_scl = 1'b0; qw();
        host_sda = 1'b1;
    endtask

    task automatic t_reset();
        check_eq("R7 reset pointer", reg_addr, 0);
        check_eq("R9 reset sda released", sda_drive_low, 0);
        check_eq("R3 reset no write strobe", reg_wr_en, 0);
    endtask

    task automatic t_read_default();
        logic a; logic [7:0] d0, d1;
        bus_start(); send_byte(8'h59, a);
        check_eq("R1 read address ack strap low", a, 0);
        recv_byte(d0, 1'b0); recv_byte(d1, 1'b1); bus_stop();
        check_eq("R5 first read from 0x00", d0, init_val(0));
        check_eq("R5 second read from 0x01", d1, init_val(1));
        check_eq("R7 pointer after two reads", reg_addr, 2);
    endtask

    task automatic t_write_burst();
        logic a0, a1, a2, a3, a4; int w0;
        w0 = wr_cnt;
        bus_start(); send_byte(8'h58, a0); send_byte(8'h10, a1);
        send_byte(8'hA1, a2); send_byte(8'hB2, a3); send_byte(8'hC3, a4); bus_stop();
        check_eq("R3 every byte acked", {a0, a1, a2, a3, a4}, 0);
        check_eq("R3 three write strobes", wr_cnt - w0, 3);
        check_eq("R3 data at 0x10", mem[8'h10], 8'hA1);
        check_eq("R3 data at 0x12", mem[8'h12], 8'hC3);
        check_eq("R7 pointer after burst", reg_addr, 8'h13);
    endtask

    task automatic t_set_ptr();
        logic a; logic [7:0] d; int w0;
        w0 = wr_cnt;
        bus_start(); send_byte(8'h58, a); send_byte(8'h11, a); bus_stop();
        check_eq("R4 no write for pointer-only", wr_cnt - w0, 0);
        check_eq("R4 pointer loaded", reg_addr, 8'h11);
        bus_start(); send_byte(8'h59, a); recv_byte(d, 1'b1); bus_stop();
        check_eq("R4 read at loaded pointer", d, 8'hB2);
    endtask

    task automatic t_repeated_start();
        logic a; logic [7:0] d0, d1, d2;
        bus_start(); send_byte(8'h58, a); send_byte(8'h10, a);
        bus_start(); send_byte(8'h59, a);
        check_eq("R8 read address acked after repeated start", a, 0);
        recv_byte(d0, 1'b0); recv_byte(d1, 1'b0); recv_byte(d2, 1'b1); bus_stop();
        check_eq("R8 first byte after repeated start", d0, 8'hA1);
        check_eq("R6 ack gives next byte", d1, 8'hB2);
        check_eq("R6 ack gives third byte", d2, 8'hC3);
        check_eq("R7 pointer after three reads", reg_addr, 8'h13);
    endtask

    task automatic t_mismatch();
        logic a0, a1, a2; int w0, d0;
        w0 = wr_cnt; d0 = drv_cycles;
        bus_start(); send_byte(8'h5A, a0); send_byte(8'h10, a1); send_byte(8'h77, a2); bus_stop();
        check_eq("R2 wrong address not acked", {a0, a1, a2}, 3'b111);
        check_eq("R2 no write on mismatch", wr_cnt - w0, 0);
        check_eq("R2 sda never driven on mismatch", drv_cycles - d0, 0);
        check_eq("R2 pointer unchanged on mismatch", reg_addr, 8'h13);
    endtask

    task automatic t_strap_high();
        logic a; logic [7:0] d;
        addr_strap = 1'b1; qw();
        bus_start(); send_byte(8'h5A, a);
        check_eq("R1 strap high write address acked", a, 0);
        send_byte(8'h20, a); send_byte(8'h3C, a); bus_stop();
        bus_start(); send_byte(8'h58, a); bus_stop();
        check_eq("R1 strap high rejects 0x58", a, 1);
        bus_start(); send_byte(8'h5A, a); send_byte(8'h20, a);
        bus_start(); send_byte(8'h5B, a); recv_byte(d, 1'b1); bus_stop();
        check_eq("R1 strap high read back", d, 8'h3C);
        addr_strap = 1'b0; qw();
    endtask

    task automatic t_wrap();
        logic a; logic [7:0] d0, d1;
        bus_start(); send_byte(8'h58, a); send_byte(8'hFE, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
        check_eq("R7 write wrapped to 0x00", mem[0], 8'h33);
        check_eq("R7 pointer after wrap", reg_addr, 8'h01);
        bus_start(); send_byte(8'h58, a); send_byte(8'hFF, a);
        bus_start(); send_byte(8'h59, a); recv_byte(d0, 1'b0); recv_byte(d1, 1'b1); bus_stop();
        check_eq("R7 read at 0xFF", d0, 8'h22);
        check_eq("R7 read wraps to 0x00", d1, 8'h33);
    endtask

    task automatic t_nack();
        logic a; logic [7:0] d0, d1; int dc;
        bus_start(); send_byte(8'h59, a); recv_byte(d0, 1'b1);
        check_eq("R5 read at pointer 0x01", d0, init_val(1));
        dc = drv_cycles;
        recv_byte(d1, 1'b1);
        bus_stop();
        check_eq("R6 sda released after nack", d1, 8'hFF);
        check_eq("R6 no drive after nack", drv_cycles - dc, 0);
    endtask

    task automatic t_disabled();
        logic a0, a1; int w0, d0, p0;
        w0 = wr_cnt; d0 = drv_cycles; p0 = reg_addr;
        enable = 1'b0; qw();
        bus_start(); send_byte(8'h58, a0); send_byte(8'h30, a1); send_byte(8'h99, a1); bus_stop();
        check_eq("R9 no ack while disabled", a0, 1);
        check_eq("R9 no write while disabled", wr_cnt - w0, 0);
        check_eq("R9 no drive while disabled", drv_cycles - d0, 0);
        check_eq("R9 pointer untouched while disabled", reg_addr, p0);
        enable = 1'b1; qw();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_read_default();
        t_write_burst();
        t_set_ptr();
        t_repeated_start();
        t_mismatch();
        t_strap_high();
        t_wrap();
        t_nack();
        t_disabled();
        check_eq("R10 sda drive changed only with SCL low", r10_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule